// File: doc/BRIEF.md
# Selectable-Period Watchdog Timer

This block is a watchdog counter that runs on the system clock. Software must restart it regularly by writing a clear code to a command port. If software fails to do so, the counter reaches a terminal count and the block reports a runaway. The terminal count is chosen by a two-bit period field, and it grows by a factor of four per step. The watchdog is armed from reset, so a program that never services it is caught even if it crashes before it can configure anything.

A control bit in the mode register chooses what a runaway does. In one setting it drives a fixed-length internal reset pulse, which also returns the watchdog to its defaults. In the other setting it raises a one-cycle interrupt and a sticky flag, and the system keeps running. Turning the watchdog off takes two steps: software first clears the enable bit, then writes a separate disable code. While the system sits in a low-power hold, signalled by an input, the count is frozen.

Top module: `wdog_top`

## Requirements
- R1: Out of reset the enable bit is 1, the period select is 00, the reset-control bit is 0, and flag_o, irq_o and wdt_rst_o are low. The counter starts from zero and counts from the first clock edge after reset is released.
- R2: A runaway is reported 2^(BASE_LOG2 + STEP*sel) counting cycles after the last counter restart, where sel is the period select. With the default parameters this gives 2^15, 2^17, 2^19 or 2^21 cycles for sel = 00, 01, 10 and 11.
- R3: Writing command 8'h4E restarts the counter from zero at that clock edge.
- R4: A mode write that changes the period select restarts the counter from zero. A mode write that keeps the same period select leaves the count running.
- R5: With the reset-control bit at 0, a runaway raises irq_o for exactly one cycle and sets flag_o in the same cycle. The counter then starts the next period from zero.
- R6: Holding flag_clr_i high for one cycle clears flag_o. The flag otherwise stays set.
- R7: With the reset-control bit at 1, a runaway drives wdt_rst_o high for exactly PULSE_LEN (16) cycles and raises neither irq_o nor flag_o. The pulse returns the mode register to its reset values and clears flag_o.
- R8: Command 8'hB1 stops the watchdog only when the enable bit is already 0. Clearing the enable bit alone does not stop counting, and 8'hB1 sent while the bit is 1 has no effect.
- R9: A mode write with enable = 1 while the watchdog is stopped re-arms it, and counting starts from zero.
- R10: While halt_i is high the count holds its value, and no runaway can occur.
- R11: Command codes other than 8'h4E and 8'hB1 have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_en_i | input | 1 | Enable bit to write |
| mode_sel_i | input | 2 | Period select to write |
| mode_rst_ctl_i | input | 1 | Reset-control bit to write (1 = runaway resets) |
| cmd_we_i | input | 1 | Command port write strobe |
| cmd_i | input | 8 | Command code |
| flag_clr_i | input | 1 | Write-one clear of the runaway flag |
| halt_i | input | 1 | System in low-power hold; freezes the count |
| en_o | output | 1 | Current enable bit |
| sel_o | output | 2 | Current period select |
| rst_ctl_o | output | 1 | Current reset-control bit |
| flag_o | output | 1 | Sticky runaway flag |
| irq_o | output | 1 | One-cycle runaway interrupt |
| wdt_rst_o | output | 1 | Internal reset pulse |

## Verification
The bench uses BASE_LOG2 = 4, so the four periods are 16, 64, 256 and 1024 cycles. It measures the distance from a restart to each runaway for every period select, which separates an error in the period decode from an off-by-one in the terminal compare. The same distance is then measured after a period change, after a same-value rewrite, after a hold window, after an unrelated command and after each step of the disable sequence. Each of these shifts the expected distance in its own way, so a restart that fires when it should not, or a missing restart, shows up as a wrong count. The reset-control path is covered by timing the pulse width, reading back the defaults and checking the distance to the next interrupt-mode runaway.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] CMD_CLEAR   = 8'h4E;
  localparam logic [CMD_W-1:0] CMD_DISABLE = 8'hB1;

  typedef struct packed {
    logic       en;
    logic [1:0] sel;
    logic       rst_ctl;
  } mode_t;

  localparam mode_t MODE_RST = '{en: 1'b1, sel: 2'b00, rst_ctl: 1'b0};
endpackage

// File: rtl/wdog_period_dec.sv
module wdog_period_dec #(
  parameter int BASE_LOG2 = 15,
  parameter int STEP      = 2,
  localparam int TW = BASE_LOG2 + 3 * STEP + 1
) (
  input  logic [1:0]    sel_i,
  output logic [TW-1:0] term_o
);
  logic [TW-1:0] opts [4];

  for (genvar g = 0; g < 4; g++) begin : g_opt
    assign opts[g] = TW'(1) << (BASE_LOG2 + STEP * g);
  end

  assign term_o = opts[sel_i];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int BASE_LOG2 = 15,
  parameter int STEP      = 2,
  localparam int CW = BASE_LOG2 + 3 * STEP,
  localparam int TW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [TW-1:0] term_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] last;

  assign last     = term_i - {{CW{1'b0}}, 1'b1};
  assign expire_o = run_i && !clr_i && ({1'b0, cnt_q} == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (run_i) begin
      if (expire_o)    cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10: held count must not move
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q));
  // R2: count never reaches the terminal value
  assert_below_term_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cnt_q} < term_i));
endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen #(
  parameter int PULSE_LEN = 16,
  localparam int RW = $clog2(PULSE_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rst_o
);
  logic [RW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (trig_i)         left_q <= RW'(PULSE_LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign rst_o = (left_q != '0);

  // R7: pulse is longer than a single cycle
  assert_pulse_min_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |=> rst_o);
  // R7: no retrigger while the pulse is running
  assert_no_retrig_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> !trig_i);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int BASE_LOG2 = 15,
  parameter int STEP      = 2,
  parameter int PULSE_LEN = 16,
  localparam int TW = BASE_LOG2 + 3 * STEP + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_we_i,
  input  logic             mode_en_i,
  input  logic [1:0]       mode_sel_i,
  input  logic             mode_rst_ctl_i,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             flag_clr_i,
  input  logic             halt_i,
  output logic             en_o,
  output logic [1:0]       sel_o,
  output logic             rst_ctl_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             wdt_rst_o
);
  mode_t         mode_q;
  logic          active_q, flag_q, irq_q;
  logic          soft_rst, sel_chg, rearm, do_clear, do_dis;
  logic          clr, run, expire, trig;
  logic [TW-1:0] term;

  assign soft_rst = wdt_rst_o;
  assign sel_chg  = mode_we_i && (mode_sel_i != mode_q.sel);
  assign rearm    = mode_we_i && mode_en_i && !active_q;
  assign do_clear = cmd_we_i && (cmd_i == CMD_CLEAR);
  assign do_dis   = cmd_we_i && (cmd_i == CMD_DISABLE) && !mode_q.en;
  assign clr      = soft_rst || do_clear || sel_chg || rearm || !active_q;
  assign run      = active_q && !halt_i && !soft_rst;
  assign trig     = expire && mode_q.rst_ctl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_RST;
      active_q <= 1'b1;
    end else if (soft_rst) begin
      mode_q   <= MODE_RST;
      active_q <= 1'b1;
    end else begin
      if (mode_we_i) mode_q <= '{en: mode_en_i, sel: mode_sel_i, rst_ctl: mode_rst_ctl_i};
      if (rearm)       active_q <= 1'b1;
      else if (do_dis) active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= expire && !mode_q.rst_ctl;
      if (soft_rst)                       flag_q <= 1'b0;
      else if (expire && !mode_q.rst_ctl) flag_q <= 1'b1;
      else if (flag_clr_i)                flag_q <= 1'b0;
    end
  end

  wdog_period_dec #(.BASE_LOG2(BASE_LOG2), .STEP(STEP)) u_dec (
    .sel_i  (mode_q.sel),
    .term_o (term)
  );

  wdog_counter #(.BASE_LOG2(BASE_LOG2), .STEP(STEP)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .run_i    (run),
    .term_i   (term),
    .expire_o (expire)
  );

  wdog_rst_gen #(.PULSE_LEN(PULSE_LEN)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig),
    .rst_o  (wdt_rst_o)
  );

  assign en_o      = mode_q.en;
  assign sel_o     = mode_q.sel;
  assign rst_ctl_o = mode_q.rst_ctl;
  assign flag_o    = flag_q;
  assign irq_o     = irq_q;

  // R5: interrupt is a single-cycle pulse
  assert_irq_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R5: flag only rises together with the interrupt
  assert_flag_with_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> irq_o);
  // R7: reset pulse restores the mode defaults
  assert_defaults_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> (en_o && sel_o == 2'b00 && !rst_ctl_o && !flag_o));
  // R7: reset mode never raises the interrupt
  assert_no_irq_in_rst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> !irq_o);
endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  localparam int B = 4;
  localparam int S = 2;
  localparam int PL = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_we_i = 1'b0, mode_en_i = 1'b1, mode_rst_ctl_i = 1'b0;
  logic [1:0] mode_sel_i = 2'b00;
  logic cmd_we_i = 1'b0;
  logic [7:0] cmd_i = 8'h00;
  logic flag_clr_i = 1'b0, halt_i = 1'b0;
  logic en_o, rst_ctl_o, flag_o, irq_o, wdt_rst_o;
  logic [1:0] sel_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_top #(.BASE_LOG2(B), .STEP(S), .PULSE_LEN(PL)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_we_i(mode_we_i), .mode_en_i(mode_en_i),
    .mode_sel_i(mode_sel_i), .mode_rst_ctl_i(mode_rst_ctl_i), .cmd_we_i(cmd_we_i),
    .cmd_i(cmd_i), .flag_clr_i(flag_clr_i), .halt_i(halt_i), .en_o(en_o),
    .sel_o(sel_o), .rst_ctl_o(rst_ctl_o), .flag_o(flag_o), .irq_o(irq_o),
    .wdt_rst_o(wdt_rst_o)
  );

  function automatic int period(int sel);
    return 1 << (B + S * sel);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_mode(logic en, logic [1:0] sel, logic rc);
    mode_we_i = 1'b1; mode_en_i = en; mode_sel_i = sel; mode_rst_ctl_i = rc;
    @(negedge clk);
    mode_we_i = 1'b0;
  endtask

  task automatic send(logic [7:0] code);
    cmd_we_i = 1'b1; cmd_i = code;
    @(negedge clk);
    cmd_we_i = 1'b0; cmd_i = 8'h00;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // edges from now until irq_o or wdt_rst_o shows
  task automatic measure(output int n, input int lim);
    n = 0;
    while (!(irq_o || wdt_rst_o) && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    int seen;
    idle(3);
    // R1 defaults
    chk("R1 en", int'(en_o), 1);
    chk("R1 sel", int'(sel_o), 0);
    chk("R1 rst_ctl", int'(rst_ctl_o), 0);
    chk("R1 outs", int'({flag_o, irq_o, wdt_rst_o}), 0);
    rst_ni = 1'b1;
    measure(n, 5000);
    chk("R1 first timeout", n, period(0));
    @(negedge clk);
    chk("R5 irq one cycle", int'(irq_o), 0);
    chk("R5 flag sticky", int'(flag_o), 1);

    // R2/R3 sweep over every period, interrupt mode
    for (int s = 0; s < 4; s++) begin
      wr_mode(1'b1, 2'(s), 1'b0);
      send(8'h4E);
      measure(n, 5000);
      chk("R2 period", n, period(s));
      chk("R5 irq", int'(irq_o), 1);
      chk("R5 flag", int'(flag_o), 1);
      // R5 next period restarts on its own
      @(negedge clk);
      measure(n, 5000);
      chk("R5 repeat", n, period(s) - 1);
      @(negedge clk);
    end

    // R6 flag clear
    flag_clr_i = 1'b1; @(negedge clk); flag_clr_i = 1'b0;
    chk("R6 flag cleared", int'(flag_o), 0);
    idle(3);
    chk("R6 flag stays clear", int'(flag_o), 0);

    // R3 restart mid-period
    wr_mode(1'b1, 2'd1, 1'b0);
    send(8'h4E);
    idle(30);
    send(8'h4E);
    measure(n, 5000);
    chk("R3 clear restarts", n, period(1));
    @(negedge clk);

    // R4 period change restarts, same value does not
    send(8'h4E);
    idle(40);
    wr_mode(1'b1, 2'd2, 1'b0);
    measure(n, 5000);
    chk("R4 change clears", n, period(2));
    @(negedge clk);
    send(8'h4E);
    idle(100);
    wr_mode(1'b1, 2'd2, 1'b0);
    measure(n, 5000);
    chk("R4 same keeps count", n, period(2) - 101);
    @(negedge clk);

    // R10 hold
    wr_mode(1'b1, 2'd0, 1'b0);
    send(8'h4E);
    idle(5);
    halt_i = 1'b1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq_o) seen++;
    end
    halt_i = 1'b0;
    chk("R10 no timeout in hold", seen, 0);
    measure(n, 5000);
    chk("R10 count held", n, period(0) - 5);
    @(negedge clk);

    // R11 unrelated command
    send(8'h4E);
    idle(5);
    send(8'h00);
    send(8'h4F);
    measure(n, 5000);
    chk("R11 other code ignored", n, period(0) - 7);
    @(negedge clk);

    // R8 disable code while enabled ignored
    send(8'h4E);
    send(8'hB1);
    measure(n, 5000);
    chk("R8 disable ignored when enabled", n, period(0) - 1);
    @(negedge clk);
    // R8 enable bit alone keeps counting
    wr_mode(1'b0, 2'd0, 1'b0);
    chk("R8 en readback", int'(en_o), 0);
    send(8'h4E);
    measure(n, 5000);
    chk("R8 en=0 still counts", n, period(0));
    @(negedge clk);
    // R8 full sequence stops it
    send(8'hB1);
    seen = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq_o || wdt_rst_o) seen++;
    end
    chk("R8 stopped", seen, 0);
    // R9 re-arm
    wr_mode(1'b1, 2'd0, 1'b0);
    measure(n, 5000);
    chk("R9 rearm from zero", n, period(0));
    @(negedge clk);

    // R7 reset mode: flag left set on purpose
    chk("R7 flag set before", int'(flag_o), 1);
    wr_mode(1'b1, 2'd1, 1'b1);
    send(8'h4E);
    measure(n, 5000);
    chk("R7 timeout distance", n, period(1));
    chk("R7 reset asserted", int'(wdt_rst_o), 1);
    n = 0; seen = 0;
    while (wdt_rst_o && n < 100) begin
      if (irq_o) seen++;
      @(negedge clk);
      n++;
    end
    chk("R7 pulse length", n, PL);
    chk("R7 no irq", seen, 0);
    chk("R7 en default", int'(en_o), 1);
    chk("R7 sel default", int'(sel_o), 0);
    chk("R7 rst_ctl default", int'(rst_ctl_o), 0);
    chk("R7 flag cleared", int'(flag_o), 0);
    measure(n, 5000);
    chk("R7 next period default", n, period(0));
    chk("R7 back to irq mode", int'(irq_o), 1);
    chk("R7 reset idle", int'(wdt_rst_o), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule